// File: doc/BRIEF.md
# Configurable-Format Serial Frame Transmitter

This block turns one parallel word into an asynchronous serial frame on a single output line. A frame opens with one low bit, carries 6, 7 or 8 payload bits (lowest bit first), optionally adds a parity bit, and closes with a high stop interval whose length can be half a bit, one bit or one and a half bits. When nothing is being sent the line rests high.

All timing comes from a single-cycle enable, `tick`, that the surrounding logic pulses at sixteen times the bit rate. Sixteen enables make one bit. Because the stop interval is counted in the same enables, the half-bit settings are exact and need no second clock. A word enters through a valid/ready handshake. At the handshake the block captures the word and the three format selects, so the source may change those inputs while the frame goes out. `in_ready` stays low until the stop interval has finished.

Top module: `uart_frame_tx`

## Requirements
- R1: While no frame is in progress, `txd` is 1 and `in_ready` is 1.
- R2: A frame starts on the clock edge where `in_valid` and `in_ready` are both 1. `txd` then goes to 0 and stays there for exactly 16 `tick` enables.
- R3: After the start bit, the payload goes out least significant bit first, each bit for 16 enables. The bit count comes from `cfg_width`: 0 gives 6 bits, 1 gives 7 bits, 2 or 3 gives 8 bits. Input bits above the selected count are not sent.
- R4: `cfg_parity` sets the parity bit: 0 or 3 sends none, 1 sends even parity, 2 sends odd parity. Even parity makes the count of ones across the sent payload bits and the parity bit even. Odd parity makes that count odd. The parity bit lasts 16 enables and comes straight after the last payload bit.
- R5: The stop interval drives `txd` to 1. Its length comes from `cfg_stop`: 0 gives 8 enables, 1 or 3 gives 16 enables, 2 gives 24 enables.
- R6: `in_ready` is 0 from the clock edge after acceptance until the edge that uses the last stop enable. No second word is accepted in that time, even while `in_valid` is held at 1.
- R7: The word and all three format selects are captured at acceptance. Changing `in_data`, `cfg_width`, `cfg_parity` or `cfg_stop` during a frame does not change that frame.
- R8: `busy` is always the inverse of `in_ready`.
- R9: After a synchronous reset, `txd` is 1, `in_ready` is 1 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Enable pulsed at 16 times the bit rate |
| in_valid | input | 1 | Word on `in_data` is offered |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 8 | Word to send |
| cfg_width | input | 2 | Payload bit count select |
| cfg_parity | input | 2 | Parity mode select |
| cfg_stop | input | 2 | Stop length select |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |

## Verification
A faulty sequencer state or bit counter shows up on `txd` within one bit time, i.e. 16 enables. It appears as a level that is wrong for the current position in the frame. The bench therefore compares `txd` against a frame it builds itself at every consumed enable. A wrong stop count or an early return to idle changes when `in_ready` rises. The bench checks the total number of enables against the configured frame length, so a fault there is caught at the end of the same frame. Format selects are scrambled during every frame, so any capture fault appears as a wrong bit in that frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int OVS      = 16;
  localparam int DATA_MAX = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE2 = 2'd3
  } par_mode_t;

  function automatic logic [3:0] width_bits(input logic [1:0] code);
    case (code)
      2'd0:    width_bits = 4'd6;
      2'd1:    width_bits = 4'd7;
      default: width_bits = 4'd8;
    endcase
  endfunction

  function automatic logic [4:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'd0:    stop_ticks = 5'(OVS / 2);
      2'd2:    stop_ticks = 5'(OVS + OVS / 2);
      default: stop_ticks = 5'(OVS);
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic [3:0]        nbits,
  input  logic              odd,
  output logic              par_bit
);
  logic [DATA_W-1:0] masked;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = (4'(i) < nbits) ? word[i] : 1'b0;
    end
    par_bit = (^masked) ^ odd;
  end

endmodule

// File: rtl/uart_tx_tickcnt.sv
module uart_tx_tickcnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  assign last = tick && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit); // R5

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = DATA_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  output logic              txd,
  output logic              busy
);
  localparam int CNT_W = $clog2(OVS + OVS / 2 + 1);

  tx_state_t         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [3:0]        left_q;
  logic              par_en_q;
  logic              par_bit_q;
  logic [CNT_W-1:0]  stop_q;
  logic [CNT_W-1:0]  limit;
  logic              accept;
  logic              bit_end;
  logic              par_calc;
  logic              txd_q;

  assign in_ready = (state_q == ST_IDLE);
  assign busy     = ~in_ready;
  assign accept   = in_valid && in_ready;
  assign txd      = txd_q;
  assign limit    = (state_q == ST_STOP) ? stop_q : CNT_W'(OVS);

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .word    (in_data),
    .nbits   (width_bits(cfg_width)),
    .odd     (cfg_parity == PAR_ODD),
    .par_bit (par_calc)
  );

  uart_tx_tickcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .tick  (tick && busy),
    .limit (limit),
    .last  (bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      txd_q     <= 1'b1;
      shift_q   <= '0;
      left_q    <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop_q    <= CNT_W'(OVS);
    end else begin
      case (state_q)
        ST_IDLE: begin
          txd_q <= 1'b1;
          if (accept) begin
            state_q   <= ST_START;
            txd_q     <= 1'b0;
            shift_q   <= in_data;
            left_q    <= width_bits(cfg_width);
            par_en_q  <= (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
            par_bit_q <= par_calc;
            stop_q    <= CNT_W'(stop_ticks(cfg_stop));
          end
        end
        ST_START: begin
          if (bit_end) begin
            state_q <= ST_DATA;
            txd_q   <= shift_q[0];
            shift_q <= shift_q >> 1;
            left_q  <= left_q - 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            if (left_q != 4'd0) begin
              txd_q   <= shift_q[0];
              shift_q <= shift_q >> 1;
              left_q  <= left_q - 1'b1;
            end else if (par_en_q) begin
              state_q <= ST_PAR;
              txd_q   <= par_bit_q;
            end else begin
              state_q <= ST_STOP;
              txd_q   <= 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            state_q <= ST_STOP;
            txd_q   <= 1'b1;
          end
        end
        ST_STOP: begin
          txd_q <= 1'b1;
          if (bit_end) state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
          txd_q   <= 1'b1;
        end
      endcase
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> txd); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$past(tick)) |-> $stable(txd)); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |-> txd); // R5
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tick)); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy); // R6

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_width = '0;
  logic [1:0] cfg_parity = '0;
  logic [1:0] cfg_stop = '0;
  logic       txd;
  logic       busy;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic exp_line [0:191];
  int   exp_total;

  always #2 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_width(cfg_width), .cfg_parity(cfg_parity),
    .cfg_stop(cfg_stop), .txd(txd), .busy(busy)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      tick = ($urandom_range(0, 2) == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string tag_of(input int t, input int nb, input bit pe);
    int b = t / 16;
    if (b == 0) return "R2 start";
    if (b <= nb) return "R3 data";
    if (pe && b == nb + 1) return "R4 parity";
    return "R5 stop";
  endfunction

  function automatic void build(input logic [7:0] d, input logic [1:0] w,
                                input logic [1:0] p, input logic [1:0] s);
    int nb = (w == 2'd0) ? 6 : (w == 2'd1) ? 7 : 8;
    bit pe = (p == 2'd1) || (p == 2'd2);
    int ones = 0;
    int pos = 0;
    logic pbit;
    int st = (s == 2'd0) ? 8 : (s == 2'd2) ? 24 : 16;
    for (int i = 0; i < 16; i++) exp_line[pos++] = 1'b0;
    for (int b = 0; b < nb; b++) begin
      ones += int'(d[b]);
      for (int i = 0; i < 16; i++) exp_line[pos++] = d[b];
    end
    pbit = (p == 2'd1) ? logic'(ones % 2) : logic'((ones + 1) % 2);
    if (pe) for (int i = 0; i < 16; i++) exp_line[pos++] = pbit;
    for (int i = 0; i < st; i++) exp_line[pos++] = 1'b1;
    exp_total = pos;
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] w,
                      input logic [1:0] p, input logic [1:0] s);
    int t = 0;
    int nb = (w == 2'd0) ? 6 : (w == 2'd1) ? 7 : 8;
    bit pe = (p == 2'd1) || (p == 2'd2);
    build(d, w, p, s);
    @(negedge clk);
    check(in_ready === 1'b1 && txd === 1'b1, "R1 idle before frame", int'(txd), 1);
    in_data = d; cfg_width = w; cfg_parity = p; cfg_stop = s; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      // R7: scramble inputs mid-frame; R6: keep offering a word
      in_data = 8'($urandom); cfg_width = 2'($urandom);
      cfg_parity = 2'($urandom); cfg_stop = 2'($urandom);
      in_valid = 1'($urandom);
      if (busy !== ~in_ready) check(1'b0, "R8 busy inverse", int'(busy), int'(~in_ready));
      if (in_ready === 1'b1) break;
      if (tick) begin
        if (t >= exp_total) begin
          check(1'b0, "R6 frame too long", t, exp_total);
        end else begin
          check(txd === exp_line[t], tag_of(t, nb, pe), int'(txd), int'(exp_line[t]));
        end
        t++;
      end
    end
    in_valid = 1'b0;
    check(t == exp_total, "R5 R6 frame length in ticks", t, exp_total);
    check(txd === 1'b1, "R1 idle after frame", int'(txd), 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(txd === 1'b1, "R9 reset txd", int'(txd), 1);
    check(in_ready === 1'b1, "R9 reset ready", int'(in_ready), 1);
    check(busy === 1'b0, "R9 reset busy", int'(busy), 0);
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(txd === 1'b1 && in_ready === 1'b1, "R1 idle line", int'(txd), 1);
    end
    for (int w = 0; w < 3; w++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 3; s++)
          send(8'hA5 ^ 8'(w * 9 + p * 3 + s), 2'(w), 2'(p), 2'(s));
    send(8'h00, 2'd2, 2'd1, 2'd0);
    send(8'hFF, 2'd2, 2'd2, 2'd0);
    send(8'hFF, 2'd0, 2'd1, 2'd3);
    send(8'hC0, 2'd0, 2'd2, 2'd2);
    send(8'h7F, 2'd1, 2'd3, 2'd1);
    send(8'h80, 2'd3, 2'd1, 2'd2);
    for (int k = 0; k < 40; k++)
      send(8'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule